// File: doc/BRIEF.md
# Masked Vector Gather Sequencer

This block collects the elements of a vector from scattered memory locations, one element at a time, under a per-element enable mask. A start pulse captures a 64-bit base address, sixteen signed 32-bit indices, a 2-bit scale code, the enable mask, a data-width mode and the current contents of the destination vector. For each enabled element, in ascending element order, the sequencer forms an address and issues one read on a request/response memory port. It then merges the returned data into the destination and clears that element's mask bit.

A response may carry a fault flag or a pending-trap flag. A fault stops the run with the work done so far committed, which leaves a destination and a mask that can be fed straight back in to finish the job. A trap flag on a good response is remembered and takes precedence over a later fault in the reported status. Disabled elements cost no memory cycle, and an empty mask completes at once.

Top module: `vgather_seq`

## Requirements
- R1: The read address for element e is base_addr plus the 32-bit index of element e, sign-extended to 64 bits, multiplied by 1, 2, 4 or 8 for scale_sel codes 00, 01, 10 and 11.
- R2: With wide_mode=0 there are sixteen elements: element e uses index e and takes mem_rsp_data[31:0] into dst bits [32e+31:32e]. With wide_mode=1 there are eight elements: element e uses index e and takes mem_rsp_data[63:0] into dst bits [64e+63:64e]. Output mask bits 15..8 are zero and mem_req_wide is high for every request.
- R3: Requests go out only for enabled elements, lowest element first, with at most one outstanding. An element whose mask bit is zero keeps its previous destination value.
- R4: A run that completes without a fault raises done for exactly one cycle, with mask_out all zero and the merged destination on dst_out.
- R5: A fault response on element f raises fault for one cycle. fault_elem=f and resume=0. Every enabled element below f is committed with its mask bit cleared. Element f and the enabled elements above it keep their destination value and a mask bit of one.
- R6: A good response with mem_rsp_trap=1 commits its data normally. If a later element then faults, the fault status reports the first trapping element in fault_elem with resume=1. A run that completes without a fault reports done with resume=0.
- R7: Starting again with the mask_out and dst_out of a faulted run, once the fault is gone, fetches only the remaining elements and gives the same destination as an uninterrupted run.
- R8: A start whose effective mask is zero raises done in the cycle after the start, issues no request and leaves the destination equal to dst_in.
- R9: While idle and without a start, dst_out and mask_out hold their values whatever the other inputs do.
- R10: After reset, dst_out and mask_out are zero, and done, fault, busy and mem_req_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a gather (taken while idle) |
| base_addr | input | 64 | Base address |
| idx_vec | input | 512 | Sixteen signed 32-bit indices, index e in bits [32e+31:32e] |
| scale_sel | input | 2 | Scale code 00..11 = x1, x2, x4, x8 |
| mask_in | input | 16 | Element enable mask |
| wide_mode | input | 1 | 0: 32-bit elements, 1: 64-bit elements |
| dst_in | input | 512 | Current destination vector |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Read address |
| mem_req_wide | output | 1 | Request is 64 bits wide |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 64 | Read data |
| mem_rsp_fault | input | 1 | Response is a fault (data ignored) |
| mem_rsp_trap | input | 1 | Good response with a pending trap |
| dst_out | output | 512 | Merged destination vector |
| mask_out | output | 16 | Remaining (not yet fetched) elements |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle fault pulse |
| fault_elem | output | 4 | Element reported with the fault |
| resume | output | 1 | Fault status stands for an earlier trap |

## Verification
The gather is tried with a full mask and positive indices, with a sparse mask and negative indices under response latency and a toggling ready, and in the 64-bit mode with upper mask bits that must be dropped. Together these separate address arithmetic, sign extension, lane placement and mask skipping. Fault runs place the fault in the middle and on the first enabled element, and a restart from the partial state is compared against the uninterrupted result. Trap runs, with and without a later fault, tell the resume reporting apart from a plain fault, and empty-mask starts check the one-cycle finish with no memory traffic.

// File: rtl/vgather_pkg.sv
package vgather_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ISSUE = 2'd1,
    SEQ_WAIT  = 2'd2
  } seq_state_e;

  // Scale code to left-shift amount: the code is the power of two.
  function automatic logic [1:0] scale_shift(input logic [1:0] code);
    return code;
  endfunction

endpackage

// File: rtl/vg_lane_pick.sv
module vg_lane_pick #(
  parameter int NUM_LANES  = 16,
  parameter int LANE_SEL_W = 4
) (
  input  logic [NUM_LANES-1:0]  pending,
  output logic                  any_pending,
  output logic [LANE_SEL_W-1:0] first_lane
);

  // Lowest set bit wins: scan downward so the last hit is the smallest.
  always_comb begin
    first_lane = '0;
    for (int i = NUM_LANES - 1; i >= 0; i--) begin
      if (pending[i]) first_lane = LANE_SEL_W'(i);
    end
  end

  assign any_pending = |pending;

endmodule

// File: rtl/vg_addr_gen.sv
module vg_addr_gen
  import vgather_pkg::*;
#(
  parameter int NUM_LANES  = 16,
  parameter int IDX_W      = 32,
  parameter int ADDR_W     = 64,
  parameter int LANE_SEL_W = 4
) (
  input  logic [ADDR_W-1:0]          base,
  input  logic [NUM_LANES*IDX_W-1:0] idx_vec,
  input  logic [1:0]                 scale_sel,
  input  logic [LANE_SEL_W-1:0]      lane,
  output logic [ADDR_W-1:0]          addr
);

  function automatic logic [ADDR_W-1:0] lane_offset(input logic [IDX_W-1:0] ix,
                                                    input logic [1:0] sc);
    logic [ADDR_W-1:0] ext;
    ext = {{(ADDR_W - IDX_W){ix[IDX_W-1]}}, ix};
    return ext << scale_shift(sc);
  endfunction

  logic [IDX_W-1:0] idx_arr [NUM_LANES];

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_idx
    assign idx_arr[k] = idx_vec[k*IDX_W +: IDX_W];
  end

  assign addr = base + lane_offset(idx_arr[lane], scale_sel);

endmodule

// File: rtl/vg_dest_merge.sv
module vg_dest_merge #(
  parameter int NUM_LANES  = 16,
  parameter int LANE_W     = 32,
  parameter int LANE_SEL_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [NUM_LANES*LANE_W-1:0] dst_ld,
  input  logic [NUM_LANES-1:0]        mask_ld,
  input  logic                        commit,
  input  logic [LANE_SEL_W-1:0]       commit_lane,
  input  logic                        commit_wide,
  input  logic [2*LANE_W-1:0]         commit_data,
  output logic [NUM_LANES*LANE_W-1:0] dst_q,
  output logic [NUM_LANES-1:0]        mask_q
);

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    localparam logic [LANE_SEL_W-1:0] NARROW_ID = LANE_SEL_W'(k);
    localparam logic [LANE_SEL_W-1:0] WIDE_ID   = LANE_SEL_W'(k / 2);
    localparam bit                    UPPER_HALF = (k % 2) == 1;

    logic              data_hit;
    logic              mask_hit;
    logic [LANE_W-1:0] wdata;
    logic [LANE_W-1:0] lane_q;
    logic              bit_q;

    assign data_hit = commit && (commit_wide ? (commit_lane == WIDE_ID)
                                             : (commit_lane == NARROW_ID));
    assign mask_hit = commit && (commit_lane == NARROW_ID);
    assign wdata    = (commit_wide && UPPER_HALF) ? commit_data[2*LANE_W-1:LANE_W]
                                                  : commit_data[LANE_W-1:0];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lane_q <= '0;
        bit_q  <= 1'b0;
      end else if (load) begin
        lane_q <= dst_ld[k*LANE_W +: LANE_W];
        bit_q  <= mask_ld[k];
      end else begin
        if (data_hit) lane_q <= wdata;
        if (mask_hit) bit_q  <= 1'b0;
      end
    end

    assign dst_q[k*LANE_W +: LANE_W] = lane_q;
    assign mask_q[k]                 = bit_q;
  end

  // R3: a committed element leaves the pending set
  a_r3_commit_clears_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !load) |=> !mask_q[$past(commit_lane)]);

endmodule

// File: rtl/vgather_seq.sv
module vgather_seq
  import vgather_pkg::*;
#(
  parameter int NUM_LANES = 16,
  parameter int LANE_W    = 32,
  parameter int IDX_W     = 32,
  parameter int ADDR_W    = 64
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [ADDR_W-1:0]              base_addr,
  input  logic [NUM_LANES*IDX_W-1:0]     idx_vec,
  input  logic [1:0]                     scale_sel,
  input  logic [NUM_LANES-1:0]           mask_in,
  input  logic                           wide_mode,
  input  logic [NUM_LANES*LANE_W-1:0]    dst_in,
  output logic                           mem_req_valid,
  input  logic                           mem_req_ready,
  output logic [ADDR_W-1:0]              mem_req_addr,
  output logic                           mem_req_wide,
  input  logic                           mem_rsp_valid,
  input  logic [2*LANE_W-1:0]            mem_rsp_data,
  input  logic                           mem_rsp_fault,
  input  logic                           mem_rsp_trap,
  output logic [NUM_LANES*LANE_W-1:0]    dst_out,
  output logic [NUM_LANES-1:0]           mask_out,
  output logic                           busy,
  output logic                           done,
  output logic                           fault,
  output logic [$clog2(NUM_LANES)-1:0]   fault_elem,
  output logic                           resume
);

  localparam int LANE_SEL_W = $clog2(NUM_LANES);
  localparam int WIDE_LANES = NUM_LANES / 2;

  // Lanes that exist in the chosen data width.
  function automatic logic [NUM_LANES-1:0] live_lanes(input logic wide);
    logic [NUM_LANES-1:0] m;
    m = '1;
    if (wide) m = {{(NUM_LANES - WIDE_LANES){1'b0}}, {WIDE_LANES{1'b1}}};
    return m;
  endfunction

  function automatic logic [NUM_LANES-1:0] lane_bit(input logic [LANE_SEL_W-1:0] lane);
    return NUM_LANES'(1) << lane;
  endfunction

  seq_state_e                 state_q;
  logic [LANE_SEL_W-1:0]      cur_lane_q;
  logic                       wide_q;
  logic [ADDR_W-1:0]          base_q;
  logic [NUM_LANES*IDX_W-1:0] idx_q;
  logic [1:0]                 scale_q;
  logic                       trap_pend_q;
  logic [LANE_SEL_W-1:0]      trap_lane_q;
  logic                       done_q;
  logic                       fault_q;
  logic [LANE_SEL_W-1:0]      fault_elem_q;
  logic                       resume_q;

  // Named internal events
  logic                  accept_start;
  logic [NUM_LANES-1:0]  start_mask;
  logic                  start_empty;
  logic                  pick_any;
  logic [LANE_SEL_W-1:0] pick_lane;
  logic                  issue_fire;
  logic                  rsp_ok;
  logic                  rsp_bad;
  logic [NUM_LANES-1:0]  mask_left;
  logic                  last_elem;

  assign accept_start = start && (state_q == SEQ_IDLE);
  assign start_mask   = mask_in & live_lanes(wide_mode);
  assign start_empty  = accept_start && (start_mask == '0);
  assign issue_fire   = mem_req_valid && mem_req_ready;
  assign rsp_ok       = (state_q == SEQ_WAIT) && mem_rsp_valid && !mem_rsp_fault;
  assign rsp_bad      = (state_q == SEQ_WAIT) && mem_rsp_valid && mem_rsp_fault;
  assign mask_left    = mask_out & ~lane_bit(cur_lane_q);
  assign last_elem    = rsp_ok && (mask_left == '0);

  vg_lane_pick #(
    .NUM_LANES  (NUM_LANES),
    .LANE_SEL_W (LANE_SEL_W)
  ) u_pick (
    .pending     (mask_out),
    .any_pending (pick_any),
    .first_lane  (pick_lane)
  );

  vg_addr_gen #(
    .NUM_LANES  (NUM_LANES),
    .IDX_W      (IDX_W),
    .ADDR_W     (ADDR_W),
    .LANE_SEL_W (LANE_SEL_W)
  ) u_addr (
    .base      (base_q),
    .idx_vec   (idx_q),
    .scale_sel (scale_q),
    .lane      (pick_lane),
    .addr      (mem_req_addr)
  );

  vg_dest_merge #(
    .NUM_LANES  (NUM_LANES),
    .LANE_W     (LANE_W),
    .LANE_SEL_W (LANE_SEL_W)
  ) u_merge (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (accept_start),
    .dst_ld      (dst_in),
    .mask_ld     (start_mask),
    .commit      (rsp_ok),
    .commit_lane (cur_lane_q),
    .commit_wide (wide_q),
    .commit_data (mem_rsp_data),
    .dst_q       (dst_out),
    .mask_q      (mask_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= SEQ_IDLE;
      cur_lane_q   <= '0;
      wide_q       <= 1'b0;
      base_q       <= '0;
      idx_q        <= '0;
      scale_q      <= '0;
      trap_pend_q  <= 1'b0;
      trap_lane_q  <= '0;
      done_q       <= 1'b0;
      fault_q      <= 1'b0;
      fault_elem_q <= '0;
      resume_q     <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (accept_start) begin
            wide_q       <= wide_mode;
            base_q       <= base_addr;
            idx_q        <= idx_vec;
            scale_q      <= scale_sel;
            trap_pend_q  <= 1'b0;
            trap_lane_q  <= '0;
            fault_elem_q <= '0;
            resume_q     <= 1'b0;
            if (start_empty) done_q  <= 1'b1;
            else             state_q <= SEQ_ISSUE;
          end
        end
        SEQ_ISSUE: begin
          if (issue_fire) begin
            cur_lane_q <= pick_lane;
            state_q    <= SEQ_WAIT;
          end
        end
        SEQ_WAIT: begin
          if (rsp_bad) begin
            state_q      <= SEQ_IDLE;
            fault_q      <= 1'b1;
            fault_elem_q <= trap_pend_q ? trap_lane_q : cur_lane_q;
            resume_q     <= trap_pend_q;
          end else if (rsp_ok) begin
            if (mem_rsp_trap && !trap_pend_q) begin
              trap_pend_q <= 1'b1;
              trap_lane_q <= cur_lane_q;
            end
            if (last_elem) begin
              state_q <= SEQ_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q <= SEQ_ISSUE;
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (state_q == SEQ_ISSUE) && pick_any;
  assign mem_req_wide  = wide_q;
  assign busy          = (state_q != SEQ_IDLE);
  assign done          = done_q;
  assign fault         = fault_q;
  assign fault_elem    = fault_elem_q;
  assign resume        = resume_q;

  // R4: completion leaves nothing pending
  a_r4_done_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mask_out == '0));

  // R5: everything below the reported element is already committed
  a_r5_fault_order: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> ((mask_out & (lane_bit(fault_elem) - NUM_LANES'(1))) == '0));

  // R5: a plain fault leaves its own element pending
  a_r5_fault_lane_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !resume) |-> mask_out[fault_elem]);

  // R2: upper mask half is cleared in 64-bit mode
  a_r2_wide_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wide_q |-> (mask_out[NUM_LANES-1:WIDE_LANES] == '0));

  // R9: idle results hold without a start
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == SEQ_IDLE) && !start) |=> ($stable(dst_out) && $stable(mask_out)));

endmodule

// File: tb/tb_vgather_seq.sv
module tb_vgather_seq;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [63:0]  base_addr = '0;
  logic [511:0] idx_vec;
  logic [1:0]   scale_sel = '0;
  logic [15:0]  mask_in = '0;
  logic         wide_mode = 1'b0;
  logic [511:0] dst_in = '0;
  logic         mem_req_valid;
  logic         mem_req_ready = 1'b1;
  logic [63:0]  mem_req_addr;
  logic         mem_req_wide;
  logic         mem_rsp_valid = 1'b0;
  logic [63:0]  mem_rsp_data = '0;
  logic         mem_rsp_fault = 1'b0;
  logic         mem_rsp_trap = 1'b0;
  logic [511:0] dst_out;
  logic [15:0]  mask_out;
  logic         busy, done, fault, resume;
  logic [3:0]   fault_elem;

  always #4 clk = ~clk;

  vgather_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .idx_vec(idx_vec),
    .scale_sel(scale_sel), .mask_in(mask_in), .wide_mode(wide_mode), .dst_in(dst_in),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_req_wide(mem_req_wide), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .mem_rsp_fault(mem_rsp_fault), .mem_rsp_trap(mem_rsp_trap), .dst_out(dst_out),
    .mask_out(mask_out), .busy(busy), .done(done), .fault(fault), .fault_elem(fault_elem),
    .resume(resume)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Index vector held as an array, packed for the port
  logic [31:0] idx_arr [16];
  always_comb begin
    for (int k = 0; k < 16; k++) idx_vec[k*32 +: 32] = idx_arr[k];
  end

  // Memory contents: a function of the address
  function automatic logic [63:0] mdata(input logic [63:0] a);
    return {a[31:0] ^ 32'h5A5A_1234, a[31:0] + 32'h0F0F_0001};
  endfunction

  function automatic logic [63:0] ref_addr(input logic [63:0] b, input logic [31:0] ix,
                                           input logic [1:0] sc);
    longint s;
    s = longint'($signed(ix));
    return b + 64'(s * (longint'(1) << sc));
  endfunction

  // Environment configuration
  int          lat_cfg = 0;
  bit          rdy_toggle = 1'b0;
  bit          fault_on = 1'b0;
  logic [63:0] fault_addr = '0;
  bit          trap_on = 1'b0;
  logic [63:0] trap_addr = '0;

  // Memory responder
  logic        pend = 1'b0;
  logic [63:0] paddr = '0;
  int          cnt = 0;
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    mem_rsp_fault <= 1'b0;
    mem_rsp_trap  <= 1'b0;
    mem_req_ready <= rdy_toggle ? ~mem_req_ready : 1'b1;
    if (pend) begin
      if (cnt == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mdata(paddr);
        mem_rsp_fault <= fault_on && (paddr == fault_addr);
        mem_rsp_trap  <= trap_on && (paddr == trap_addr);
        pend          <= 1'b0;
      end else begin
        cnt <= cnt - 1;
      end
    end
    if (mem_req_valid && mem_req_ready) begin
      pend  <= 1'b1;
      paddr <= mem_req_addr;
      cnt   <= lat_cfg;
    end
  end

  // Reference model state
  logic [63:0]  addr_q [$];
  int           nreq = 0;
  int           exp_nreq = 0;
  bit           cur_wide = 1'b0;
  logic [511:0] exp_dst;
  logic [15:0]  exp_mask;
  bit           exp_fault;
  int           exp_fe;
  bit           exp_res;
  int           last_cyc;

  // Per-clock comparison of every memory request against the model
  always @(negedge clk) begin
    if (rst_n && mem_req_valid && mem_req_ready) begin : mon
      logic [63:0] e;
      nreq++;
      if (addr_q.size() == 0) begin
        check(1'b0, "R3", "request beyond enabled elements", mem_req_addr, '0);
      end else begin
        e = addr_q.pop_front();
        check(mem_req_addr === e, "R1", "request address", mem_req_addr, e);
        check(mem_req_wide === cur_wide, "R2", "request width", mem_req_wide, cur_wide);
      end
    end
  end

  task automatic run_gather(input logic [63:0] b, input logic [1:0] sc, input logic [15:0] m,
                            input bit w, input logic [511:0] d, input string req);
    logic [63:0] a;
    logic [63:0] dv;
    bit          trap_seen;
    int          trap_l;
    int          lanes;
    int          cyc;
    exp_dst   = d;
    exp_mask  = w ? (m & 16'h00FF) : m;
    exp_fault = 1'b0;
    exp_fe    = 0;
    exp_res   = 1'b0;
    trap_seen = 1'b0;
    trap_l    = 0;
    addr_q.delete();
    nreq      = 0;
    exp_nreq  = 0;
    cur_wide  = w;
    lanes     = w ? 8 : 16;
    for (int l = 0; l < lanes; l++) begin
      if (exp_mask[l] && !exp_fault) begin
        a = ref_addr(b, idx_arr[l], sc);
        addr_q.push_back(a);
        exp_nreq++;
        if (fault_on && a == fault_addr) begin
          exp_fault = 1'b1;
          exp_fe    = trap_seen ? trap_l : l;
          exp_res   = trap_seen;
        end else begin
          dv = mdata(a);
          if (w) exp_dst[64*l +: 64] = dv;
          else   exp_dst[32*l +: 32] = dv[31:0];
          exp_mask[l] = 1'b0;
          if (trap_on && a == trap_addr && !trap_seen) begin
            trap_seen = 1'b1;
            trap_l    = l;
          end
        end
      end
    end
    @(negedge clk);
    base_addr = b; scale_sel = sc; mask_in = m; wide_mode = w; dst_in = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!(done || fault) && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    last_cyc = cyc;
    check(done === !exp_fault, "R4", "done status", done, !exp_fault);
    check(fault === exp_fault, "R5", "fault status", fault, exp_fault);
    if (exp_fault) begin
      check(fault_elem === 4'(exp_fe), "R5", "fault element", fault_elem, exp_fe);
    end
    check(resume === exp_res, "R6", "resume flag", resume, exp_res);
    check(dst_out === exp_dst, req, "destination", dst_out, exp_dst);
    check(mask_out === exp_mask, req, "mask", mask_out, exp_mask);
    check(nreq == exp_nreq, "R3", "request count", nreq, exp_nreq);
    @(negedge clk);
    check(!done && !fault, "R4", "status pulse lasts one cycle", {done, fault}, 2'b00);
  endtask

  logic [511:0] ref_full, part_dst, hold_dst;
  logic [15:0]  part_mask, hold_mask;
  localparam logic [63:0] BASE_A = 64'h0000_1000_0000_0000;
  localparam logic [63:0] BASE_B = 64'h0000_0000_8000_0040;

  initial begin
    for (int k = 0; k < 16; k++) idx_arr[k] = 32'(k * 3 + 1);

    // R10: reset state
    repeat (3) @(negedge clk);
    check(dst_out === '0, "R10", "dst after reset", dst_out, '0);
    check(mask_out === '0, "R10", "mask after reset", mask_out, '0);
    check(!done && !fault && !busy, "R10", "status after reset", {done, fault, busy}, '0);
    check(!mem_req_valid, "R10", "no request in reset", mem_req_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: full mask, positive indices, scale x4
    run_gather(BASE_A, 2'b10, 16'hFFFF, 1'b0, {16{32'hDEAD_BEEF}}, "R1");
    ref_full = dst_out;

    // R3: sparse mask, negative indices, latency and stalls, scale x8
    for (int k = 0; k < 16; k++) idx_arr[k] = 32'(7 - k * 5);
    lat_cfg = 3; rdy_toggle = 1'b1;
    run_gather(BASE_B, 2'b11, 16'hA5C3, 1'b0, {8{64'h0123_4567_89AB_CDEF}}, "R3");

    // R2: 64-bit mode, upper mask half dropped, scale x2
    lat_cfg = 1; rdy_toggle = 1'b0;
    run_gather(BASE_B, 2'b01, 16'hFF5A, 1'b1, {16{32'h1111_2222}}, "R2");
    check(mask_out[15:8] === 8'h00, "R2", "upper mask half", mask_out, '0);

    // R5: fault on element 5 of a full run
    for (int k = 0; k < 16; k++) idx_arr[k] = 32'(k * 3 + 1);
    lat_cfg = 0;
    fault_on = 1'b1; fault_addr = ref_addr(BASE_A, idx_arr[5], 2'b10);
    run_gather(BASE_A, 2'b10, 16'hFFFF, 1'b0, {16{32'hDEAD_BEEF}}, "R5");
    check(mask_out === 16'hFFE0, "R5", "partial mask", mask_out, 16'hFFE0);
    part_dst = dst_out; part_mask = mask_out;

    // R7: restart from the partial state
    fault_on = 1'b0; lat_cfg = 2;
    run_gather(BASE_A, 2'b10, part_mask, 1'b0, part_dst, "R7");
    check(dst_out === ref_full, "R7", "restart equals uninterrupted", dst_out, ref_full);
    check(nreq == 11, "R7", "only remaining elements fetched", nreq, 11);

    // R5: fault on the first enabled element
    fault_on = 1'b1; fault_addr = ref_addr(BASE_A, idx_arr[0], 2'b00);
    run_gather(BASE_A, 2'b00, 16'h0F0F, 1'b0, {16{32'hCAFE_0000}}, "R5");
    check(dst_out === {16{32'hCAFE_0000}}, "R5", "nothing committed", dst_out, {16{32'hCAFE_0000}});

    // R6: trap on element 2, then fault on element 6
    trap_on = 1'b1; trap_addr = ref_addr(BASE_B, idx_arr[2], 2'b01);
    fault_addr = ref_addr(BASE_B, idx_arr[6], 2'b01);
    run_gather(BASE_B, 2'b01, 16'hFFFF, 1'b0, '0, "R6");
    check(fault_elem === 4'd2 && resume === 1'b1, "R6", "trap reported in place of fault",
          {fault_elem, resume}, {4'd2, 1'b1});

    // R6: trap without a later fault completes normally
    fault_on = 1'b0; trap_addr = ref_addr(BASE_B, idx_arr[3], 2'b01);
    run_gather(BASE_B, 2'b01, 16'h00FF, 1'b1, '1, "R6");
    trap_on = 1'b0;

    // R8: empty masks, including one emptied by the 64-bit mode
    run_gather(BASE_A, 2'b10, 16'h0000, 1'b0, {16{32'h7777_0001}}, "R8");
    check(last_cyc == 1, "R8", "done in cycle after start", last_cyc, 1);
    check(nreq == 0, "R8", "no requests", nreq, 0);
    run_gather(BASE_A, 2'b10, 16'hFF00, 1'b1, {16{32'h0BAD_F00D}}, "R8");
    check(last_cyc == 1, "R8", "done in cycle after start (wide)", last_cyc, 1);

    // R9: outputs hold while idle and inputs move
    run_gather(BASE_A, 2'b10, 16'h3C3C, 1'b0, {16{32'h5555_AAAA}}, "R9");
    hold_dst = dst_out; hold_mask = mask_out;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      dst_in = {16{32'(c * 977)}}; mask_in = 16'(c * 4099); base_addr = 64'(c); wide_mode = c[0];
    end
    @(negedge clk);
    check(dst_out === hold_dst, "R9", "dst held while idle", dst_out, hold_dst);
    check(mask_out === hold_mask, "R9", "mask held while idle", mask_out, hold_mask);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL R4 watchdog: actual hung run, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule